// File: doc/BRIEF.md
# Configurable I2S Transmit Controller

This block turns stereo sample pairs into a serial audio stream. A writer pushes a left/right pair per write into a small transmit FIFO. At the start of every frame the serializer takes one pair and shifts it out MSB first. Each sample goes out in its own half-frame. The framing is selected at run time: standard I2S, left-justified or right-justified. An option inverts the word-select polarity.

In master mode the block divides its own root clock to make the bit clock and the word-select (LR) clock. Two selections set the division: the root-to-frame ratio and the bit clocks per frame. In slave mode it synchronises external bit and word-select clocks into the root domain and follows them.

Configuration requests are validated as they are written, and the accepted settings are reflected on read-back outputs. Status outputs report FIFO occupancy, a full flag and a sticky underrun flag.

Top module: `i2s_tx`

## Requirements
- R1: A configuration write requesting a root-to-frame ratio of 384, 512 or 768 selects that ratio. Any other requested value selects 256. Reset selects 256.
- R2: A configuration write requesting 16, 24, 32 or 48 bit clocks per frame selects that value. Any other value leaves the previous selection in place. Reset selects 32.
- R3: A configuration write requesting a sample width of 8, 16 or 24 selects it. Any other value keeps the previous width. Reset selects 16.
- R4: Format code 0 is I2S, 1 is left-justified and 2 is right-justified. Code 3 is ignored and the previous format is kept. Reset selects code 0. A half-frame of H = bitsPerFrame/2 slots is numbered 0 to H-1 from the word-select edge. Samples go out MSB first, starting at slot 1 for I2S and slot 0 for left-justified. For right-justified the LSB lands in slot H-1. All other slots are low.
- R5: Every frame starts with the left half. Word-select is low during the left half in I2S, and high during the left half in both justified formats. The inversion bit flips this level.
- R6: In master mode the bit clock period is floor(ratio/bitsPerFrame) root cycles. The bit clock is low for the first floor(period/2) cycles of each period. Each half-frame holds H bit clocks, and word-select changes only while the bit clock is low. In slave mode the bit and word-select outputs stay low, and bits advance on falling edges of the external bit clock. An external word-select change restarts the slot count at 0.
- R7: One stereo pair is popped from the FIFO at each frame start, only while active=1 and pause=0. When either condition fails, the serial data output stays low and the FIFO is left untouched.
- R8: While the flush input is high, the FIFO occupancy is 0 and writes are discarded.
- R9: The occupancy output counts 0 to FIFO_DEPTH, and the full flag is high exactly at FIFO_DEPTH. A write while full is dropped.
- R10: A frame start while transmitting with an empty FIFO sends zero samples and sets the sticky underrun flag. The flag is cleared by the clear input and is otherwise held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampled root clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rfs | input | 10 | Requested root-to-frame ratio |
| cfg_bfs | input | 6 | Requested bit clocks per frame |
| cfg_width | input | 5 | Requested sample width in bits |
| cfg_fmt | input | 2 | Requested framing code |
| cfg_lrinv | input | 1 | Word-select inversion |
| cfg_slave | input | 1 | 1 = follow external clocks |
| tx_active | input | 1 | Transmit path active |
| tx_pause | input | 1 | Transmit path paused |
| fifo_flush | input | 1 | Flush level, FIFO held empty while high |
| wr_en | input | 1 | Push one stereo pair |
| wr_left | input | SAMPLE_W | Left sample, LSB aligned |
| wr_right | input | SAMPLE_W | Right sample, LSB aligned |
| ur_clr | input | 1 | Clear the underrun flag |
| bclk_i | input | 1 | External bit clock (slave) |
| lrclk_i | input | 1 | External word-select (slave) |
| bclk_o | output | 1 | Generated bit clock (master) |
| lrclk_o | output | 1 | Generated word-select (master) |
| sdata_o | output | 1 | Serial data |
| fifo_level | output | LVL_W | FIFO occupancy |
| fifo_full | output | 1 | FIFO full |
| underrun | output | 1 | Sticky underrun flag |
| cur_rfs | output | 10 | Accepted ratio |
| cur_bfs | output | 6 | Accepted bit clocks per frame |
| cur_width | output | 5 | Accepted sample width |
| cur_fmt | output | 2 | Accepted format code |

## Verification
Some properties are checked on every cycle: the occupancy bound, dropped writes when full, the empty FIFO under flush, the hold and clear of the underrun flag, the legal ratio read-back, and the rule that master word-select moves only while the bit clock is low.

Other behaviour needs a decoder in the bench. Slot placement per format, word-select polarity with inversion, bit clock period and slot count per half, pair ordering across frames, and slave-mode tracking are all recovered from the serial pins. They are compared against pairs the bench generated, so only its scenarios can show them.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_BAD = 2'd3
  } fmt_e;

  function automatic logic [9:0] rfs_val(input logic [1:0] s);
    case (s)
      2'd1:    return 10'd384;
      2'd2:    return 10'd512;
      2'd3:    return 10'd768;
      default: return 10'd256;
    endcase
  endfunction

  function automatic logic [5:0] bfs_val(input logic [1:0] s);
    case (s)
      2'd0:    return 6'd16;
      2'd1:    return 6'd24;
      2'd2:    return 6'd32;
      default: return 6'd48;
    endcase
  endfunction

  function automatic logic [4:0] width_val(input logic [1:0] s);
    case (s)
      2'd0:    return 5'd8;
      2'd1:    return 5'd16;
      default: return 5'd24;
    endcase
  endfunction

  // root cycles per bit clock: floor(ratio / bits per frame)
  function automatic logic [5:0] bit_div(input logic [1:0] r, input logic [1:0] b);
    case ({r, b})
      4'h0: return 6'd16;  4'h1: return 6'd10;  4'h2: return 6'd8;   4'h3: return 6'd5;
      4'h4: return 6'd24;  4'h5: return 6'd16;  4'h6: return 6'd12;  4'h7: return 6'd8;
      4'h8: return 6'd32;  4'h9: return 6'd21;  4'hA: return 6'd16;  4'hB: return 6'd10;
      4'hC: return 6'd48;  4'hD: return 6'd32;  4'hE: return 6'd24;  default: return 6'd16;
    endcase
  endfunction

endpackage

// File: rtl/i2s_tx_cfg.sv
module i2s_tx_cfg
  import i2s_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [9:0] req_rfs,
  input  logic [5:0] req_bfs,
  input  logic [4:0] req_width,
  input  logic [1:0] req_fmt,
  input  logic       req_inv,
  input  logic       req_slave,
  output logic [1:0] rfs_sel,
  output logic [1:0] bfs_sel,
  output logic [1:0] width_sel,
  output fmt_e       fmt,
  output logic       inv,
  output logic       slave
);

  logic [1:0] rfs_n, bfs_n, width_n;
  fmt_e       fmt_n;
  logic       inv_n, slave_n;

  always_comb begin
    rfs_n   = rfs_sel;
    bfs_n   = bfs_sel;
    width_n = width_sel;
    fmt_n   = fmt;
    inv_n   = inv;
    slave_n = slave;
    if (we) begin
      case (req_rfs)
        10'd384: rfs_n = 2'd1;
        10'd512: rfs_n = 2'd2;
        10'd768: rfs_n = 2'd3;
        default: rfs_n = 2'd0;
      endcase
      case (req_bfs)
        6'd16:   bfs_n = 2'd0;
        6'd24:   bfs_n = 2'd1;
        6'd32:   bfs_n = 2'd2;
        6'd48:   bfs_n = 2'd3;
        default: bfs_n = bfs_sel;
      endcase
      case (req_width)
        5'd8:    width_n = 2'd0;
        5'd16:   width_n = 2'd1;
        5'd24:   width_n = 2'd2;
        default: width_n = width_sel;
      endcase
      if (req_fmt != 2'd3) fmt_n = fmt_e'(req_fmt);
      inv_n   = req_inv;
      slave_n = req_slave;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rfs_sel   <= 2'd0;
      bfs_sel   <= 2'd2;
      width_sel <= 2'd1;
      fmt       <= FMT_I2S;
      inv       <= 1'b0;
      slave     <= 1'b0;
    end else begin
      rfs_sel   <= rfs_n;
      bfs_sel   <= bfs_n;
      width_sel <= width_n;
      fmt       <= fmt_n;
      inv       <= inv_n;
      slave     <= slave_n;
    end
  end

endmodule

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
  parameter  int DEPTH = 8,
  parameter  int DW    = 48,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q, wp_n, rp_n;
  logic [LW-1:0] cnt_n;
  logic          do_wr, do_rd;

  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);
  assign head  = mem[rp_q];

  always_comb begin
    do_wr = wr_en & ~flush & ~full;
    do_rd = rd_en & ~flush & ~empty;
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = level;
    if (do_wr) wp_n = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
    if (do_rd) rp_n = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
    case ({do_wr, do_rd})
      2'b10:   cnt_n = level + LW'(1);
      2'b01:   cnt_n = level - LW'(1);
      default: cnt_n = level;
    endcase
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      level <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      level <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wr_data;
  end

endmodule

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen #(
  parameter  int DIV_W  = 6,
  parameter  int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave,
  input  logic [DIV_W-1:0]  div,
  input  logic [SLOT_W-1:0] half_bits,
  input  logic              left_lvl,
  input  logic              bclk_i,
  input  logic              lrclk_i,
  output logic [SLOT_W-1:0] slot,
  output logic              left,
  output logic              frame_start,
  output logic              bclk_o,
  output logic              lrclk_o
);

  logic [DIV_W-1:0]  bc_q, bc_n;
  logic [SLOT_W-1:0] slot_n;
  logic              left_n;
  logic              b_s1, b_s2, b_prev, l_s1, l_s2, l_last, l_last_n;
  logic              adv, fall;

  assign adv  = (bc_q >= div - DIV_W'(1));
  assign fall = b_prev & ~b_s2;

  always_comb begin
    bc_n        = adv ? '0 : bc_q + DIV_W'(1);
    slot_n      = slot;
    left_n      = left;
    l_last_n    = l_last;
    frame_start = 1'b0;
    if (!slave) begin
      if (adv) begin
        if (slot >= half_bits - SLOT_W'(1)) begin
          slot_n      = '0;
          left_n      = ~left;
          frame_start = ~left;
        end else begin
          slot_n = slot + SLOT_W'(1);
        end
      end
    end else if (fall) begin
      l_last_n = l_s2;
      if (l_s2 != l_last) begin
        slot_n      = '0;
        left_n      = (l_s2 == left_lvl);
        frame_start = (l_s2 == left_lvl);
      end else if (slot != {SLOT_W{1'b1}}) begin
        slot_n = slot + SLOT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_q   <= '0;
      slot   <= '0;
      left   <= 1'b1;
      b_s1   <= 1'b0;
      b_s2   <= 1'b0;
      b_prev <= 1'b0;
      l_s1   <= 1'b0;
      l_s2   <= 1'b0;
      l_last <= 1'b0;
    end else begin
      bc_q   <= bc_n;
      slot   <= slot_n;
      left   <= left_n;
      b_s1   <= bclk_i;
      b_s2   <= b_s1;
      b_prev <= b_s2;
      l_s1   <= lrclk_i;
      l_s2   <= l_s1;
      l_last <= l_last_n;
    end
  end

  assign bclk_o  = ~slave & (bc_q >= {1'b0, div[DIV_W-1:1]});
  assign lrclk_o = ~slave & (left ? left_lvl : ~left_lvl);

endmodule

// File: rtl/i2s_tx_ser.sv
module i2s_tx_ser
  import i2s_tx_pkg::*;
#(
  parameter  int SW     = 24,
  parameter  int SLOT_W = 5,
  localparam int IW     = SLOT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              frame_start,
  input  logic              fifo_empty,
  input  logic [2*SW-1:0]   head,
  input  logic [SLOT_W-1:0] slot,
  input  logic              left,
  input  fmt_e              fmt,
  input  logic [4:0]        width,
  input  logic [SLOT_W-1:0] half_bits,
  input  logic              ur_clr,
  output logic              pop,
  output logic              sdata,
  output logic              underrun
);

  logic [2*SW-1:0]      cur_q, cur_n;
  logic                 ur_n;
  logic [SW-1:0]        sample, shifted;
  logic signed [IW-1:0] idx, wi, ki, hi;

  assign pop = frame_start & run & ~fifo_empty;

  always_comb begin
    cur_n = cur_q;
    ur_n  = underrun;
    if (!run) cur_n = '0;
    else if (frame_start) cur_n = fifo_empty ? '0 : head;
    if (frame_start && run && fifo_empty) ur_n = 1'b1;
    if (ur_clr) ur_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q    <= '0;
      underrun <= 1'b0;
    end else begin
      cur_q    <= cur_n;
      underrun <= ur_n;
    end
  end

  always_comb begin
    wi = IW'(width);
    ki = IW'(slot);
    hi = IW'(half_bits);
    case (fmt)
      FMT_LJ:  idx = wi - ki - IW'(1);
      FMT_RJ:  idx = hi - ki - IW'(1);
      default: idx = wi - ki;
    endcase
    sample  = left ? cur_q[2*SW-1:SW] : cur_q[SW-1:0];
    shifted = sample >> idx[SLOT_W-1:0];
    sdata   = run & (idx >= 0) & (idx < wi) & shifted[0];
  end

endmodule

// File: rtl/i2s_tx.sv
module i2s_tx
  import i2s_tx_pkg::*;
#(
  parameter  int FIFO_DEPTH = 8,
  parameter  int SAMPLE_W   = 24,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [9:0]          cfg_rfs,
  input  logic [5:0]          cfg_bfs,
  input  logic [4:0]          cfg_width,
  input  logic [1:0]          cfg_fmt,
  input  logic                cfg_lrinv,
  input  logic                cfg_slave,
  input  logic                tx_active,
  input  logic                tx_pause,
  input  logic                fifo_flush,
  input  logic                wr_en,
  input  logic [SAMPLE_W-1:0] wr_left,
  input  logic [SAMPLE_W-1:0] wr_right,
  input  logic                ur_clr,
  input  logic                bclk_i,
  input  logic                lrclk_i,
  output logic                bclk_o,
  output logic                lrclk_o,
  output logic                sdata_o,
  output logic [LVL_W-1:0]    fifo_level,
  output logic                fifo_full,
  output logic                underrun,
  output logic [9:0]          cur_rfs,
  output logic [5:0]          cur_bfs,
  output logic [4:0]          cur_width,
  output logic [1:0]          cur_fmt
);

  localparam int SLOT_W = 5;

  logic [1:0]            rfs_sel, bfs_sel, width_sel;
  fmt_e                  fmt;
  logic                  lr_inv, slave_q, left_lvl, run;
  logic [5:0]            div;
  logic [SLOT_W-1:0]     half_bits, slot;
  logic                  half_left, frame_start, pop, empty;
  logic [2*SAMPLE_W-1:0] head;

  i2s_tx_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we),
    .req_rfs(cfg_rfs), .req_bfs(cfg_bfs), .req_width(cfg_width),
    .req_fmt(cfg_fmt), .req_inv(cfg_lrinv), .req_slave(cfg_slave),
    .rfs_sel(rfs_sel), .bfs_sel(bfs_sel), .width_sel(width_sel),
    .fmt(fmt), .inv(lr_inv), .slave(slave_q)
  );

  assign cur_rfs   = rfs_val(rfs_sel);
  assign cur_bfs   = bfs_val(bfs_sel);
  assign cur_width = width_val(width_sel);
  assign cur_fmt   = fmt;
  assign div       = bit_div(rfs_sel, bfs_sel);
  assign half_bits = cur_bfs[5:1];
  assign left_lvl  = (fmt != FMT_I2S) ^ lr_inv;
  assign run       = tx_active & ~tx_pause;

  i2s_tx_fifo #(.DEPTH(FIFO_DEPTH), .DW(2*SAMPLE_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(fifo_flush),
    .wr_en(wr_en), .wr_data({wr_left, wr_right}), .rd_en(pop),
    .head(head), .level(fifo_level), .full(fifo_full), .empty(empty)
  );

  i2s_tx_clkgen #(.DIV_W(6), .SLOT_W(SLOT_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .slave(slave_q), .div(div),
    .half_bits(half_bits), .left_lvl(left_lvl),
    .bclk_i(bclk_i), .lrclk_i(lrclk_i),
    .slot(slot), .left(half_left), .frame_start(frame_start),
    .bclk_o(bclk_o), .lrclk_o(lrclk_o)
  );

  i2s_tx_ser #(.SW(SAMPLE_W), .SLOT_W(SLOT_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .run(run), .frame_start(frame_start),
    .fifo_empty(empty), .head(head), .slot(slot), .left(half_left),
    .fmt(fmt), .width(cur_width), .half_bits(half_bits), .ur_clr(ur_clr),
    .pop(pop), .sdata(sdata_o), .underrun(underrun)
  );

endmodule

// File: rtl/i2s_tx_chk.sv
module i2s_tx_chk #(
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          wr_en,
  input logic          fifo_full,
  input logic [LW-1:0] fifo_level,
  input logic          underrun,
  input logic          ur_clr,
  input logic          slave,
  input logic          half_left,
  input logic          bclk_o,
  input logic [9:0]    cur_rfs
);

  p_level_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full && wr_en && !flush |=> fifo_level <= $past(fifo_level));

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> fifo_level == '0 && !fifo_full);

  p_ur_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    underrun && !ur_clr |=> underrun);

  p_ur_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ur_clr |=> !underrun);

  p_rfs_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cur_rfs == 10'd256 || cur_rfs == 10'd384 || cur_rfs == 10'd512 || cur_rfs == 10'd768);

  p_lr_low_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !slave && $past(!slave) && half_left != $past(half_left) |-> !bclk_o);

endmodule

bind i2s_tx i2s_tx_chk #(.DEPTH(FIFO_DEPTH), .LW(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(fifo_flush), .wr_en(wr_en),
  .fifo_full(fifo_full), .fifo_level(fifo_level), .underrun(underrun),
  .ur_clr(ur_clr), .slave(slave_q), .half_left(half_left),
  .bclk_o(bclk_o), .cur_rfs(cur_rfs)
);

// File: tb/i2s_tx_tb.sv
module i2s_tx_tb;

  localparam int DEPTH = 8;

  logic        clk, rst_n;
  logic        cfg_we, cfg_lrinv, cfg_slave;
  logic [9:0]  cfg_rfs;
  logic [5:0]  cfg_bfs;
  logic [4:0]  cfg_width;
  logic [1:0]  cfg_fmt;
  logic        tx_active, tx_pause, fifo_flush, wr_en, ur_clr, bclk_i, lrclk_i;
  logic [23:0] wr_left, wr_right;
  logic        bclk_o, lrclk_o, sdata_o, fifo_full, underrun;
  logic [3:0]  fifo_level;
  logic [9:0]  cur_rfs;
  logic [5:0]  cur_bfs;
  logic [4:0]  cur_width;
  logic [1:0]  cur_fmt;

  i2s_tx #(.FIFO_DEPTH(DEPTH), .SAMPLE_W(24)) u_dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- serial monitor (master mode) ----------------
  bit          mon_en = 0, started, have_left, rise_seen;
  logic        prev_b, mon_lr, m_leftlvl;
  int          cyc, nb, m_div, m_h, m_w, m_fmt, nexp, got, mon_bad, half_bad, per_bad;
  logic [63:0] bits;
  logic [23:0] left_v;
  logic [23:0] exp_l [DEPTH];
  logic [23:0] exp_r [DEPTH];

  function automatic int slot_off(input int f, input int h, input int w);
    if (f == 0) return 1;
    if (f == 1) return 0;
    return h - w;
  endfunction

  function automatic logic [23:0] extract(input logic [63:0] b, input int off, input int w);
    logic [23:0] v = '0;
    for (int i = 0; i < w; i++) v[w-1-i] = b[off+i];
    return v;
  endfunction

  function automatic bit stray(input logic [63:0] b, input int off, input int w, input int h);
    for (int i = 0; i < h; i++)
      if ((i < off || i >= off + w) && b[i]) return 1;
    return 0;
  endfunction

  task automatic finish_half();
    logic [23:0] v;
    int off;
    off = slot_off(m_fmt, m_h, m_w);
    if (nb != m_h) half_bad++;
    v = extract(bits, off, m_w);
    if (stray(bits, off, m_w, m_h)) mon_bad++;
    if (mon_lr == m_leftlvl) begin
      left_v = v; have_left = 1;
    end else if (have_left) begin
      have_left = 0;
      if (left_v != 0 || v != 0) begin
        if (!(got < nexp && left_v == exp_l[got] && v == exp_r[got])) mon_bad++;
        got++;
      end
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      cyc++;
      if (bclk_o && !prev_b) begin
        if (rise_seen && cyc != m_div) per_bad++;
        rise_seen = 1;
        cyc = 0;
        if (lrclk_o != mon_lr) begin
          if (started) finish_half();
          started = 1; nb = 0; bits = '0; mon_lr = lrclk_o;
        end
        if (nb < 64) bits[nb] = sdata_o;
        nb++;
      end
      prev_b = bclk_o;
    end
  end

  // ---------------- drive helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfg(input int rfs, input int bfs, input int w, input int f, input bit inv, input bit slv);
    cfg_rfs = 10'(rfs); cfg_bfs = 6'(bfs); cfg_width = 5'(w);
    cfg_fmt = 2'(f); cfg_lrinv = inv; cfg_slave = slv; cfg_we = 1;
    tick(1);
    cfg_we = 0;
    tick(1);
  endtask

  task automatic flush_fifo();
    fifo_flush = 1; tick(1); fifo_flush = 0; tick(1);
  endtask

  task automatic push(input logic [23:0] l, input logic [23:0] r);
    wr_left = l; wr_right = r; wr_en = 1; tick(1); wr_en = 0;
  endtask

  function automatic logic [23:0] rnd_sample(input int w);
    logic [23:0] m = 24'((64'd1 << w) - 1);
    return (24'($urandom) & m) | 24'(64'd1 << (w - 1));
  endfunction

  task automatic master_run(input int f, input bit inv, input int rfs, input int bfs, input int w, input int n);
    cfg(rfs, bfs, w, f, inv, 0);
    flush_fifo();
    for (int i = 0; i < n; i++) begin
      exp_l[i] = rnd_sample(w); exp_r[i] = rnd_sample(w);
      push(exp_l[i], exp_r[i]);
    end
    @(negedge clk);
    chk(fifo_level == 4'(n), "R9 level after fill", int'(fifo_level), n);
    m_div = rfs / bfs; m_h = bfs / 2; m_w = w; m_fmt = f; nexp = n;
    m_leftlvl = ((f == 0) ? 1'b0 : 1'b1) ^ inv;
    started = 0; have_left = 0; rise_seen = 0; got = 0; mon_bad = 0;
    half_bad = 0; per_bad = 0; nb = 0; cyc = 0; prev_b = bclk_o; mon_lr = lrclk_o;
    mon_en = 1;
    tick(1);
    tx_active = 1;
    tick((n + 3) * rfs);
    tx_active = 0;
    mon_en = 0;
    @(negedge clk);
    chk(mon_bad == 0, "R4 R5 slot placement and LR polarity", mon_bad, 0);
    chk(got == n, "R7 pairs sent in order", got, n);
    chk(per_bad == 0, "R6 bit clock period", per_bad, 0);
    chk(half_bad == 0, "R6 slots per half", half_bad, 0);
    chk(fifo_level == 0, "R7 FIFO drained", int'(fifo_level), 0);
    chk(underrun == 1, "R10 underrun after drain", int'(underrun), 1);
    ur_clr = 1; tick(1); ur_clr = 0;
    @(negedge clk);
    chk(underrun == 0, "R10 underrun cleared", int'(underrun), 0);
  endtask

  task automatic slave_bit(input logic lr, output logic b);
    bclk_i = 0; lrclk_i = lr;
    tick(6);
    @(negedge clk);
    b = sdata_o;
    bclk_i = 1;
    tick(6);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic b;
    logic [23:0] sl, sr, gl, gr;
    bit hi_seen;
    int lvl;
    int rfs_tab [4] = '{256, 384, 512, 768};
    int bfs_tab [4] = '{16, 24, 32, 48};
    int w_tab   [3] = '{8, 16, 24};

    void'($urandom(32'd20240611));
    rst_n = 0; cfg_we = 0; cfg_rfs = 0; cfg_bfs = 0; cfg_width = 0; cfg_fmt = 0;
    cfg_lrinv = 0; cfg_slave = 0; tx_active = 0; tx_pause = 0; fifo_flush = 0;
    wr_en = 0; wr_left = 0; wr_right = 0; ur_clr = 0; bclk_i = 0; lrclk_i = 0;
    tick(4);
    rst_n = 1;
    tick(2);

    // reset state
    @(negedge clk);
    chk(cur_rfs == 256, "R1 reset ratio", int'(cur_rfs), 256);
    chk(cur_bfs == 32, "R2 reset bits per frame", int'(cur_bfs), 32);
    chk(cur_width == 16, "R3 reset width", int'(cur_width), 16);
    chk(cur_fmt == 0, "R4 reset format", int'(cur_fmt), 0);
    chk(fifo_level == 0 && !fifo_full && !underrun && !sdata_o, "R9 reset status", int'(fifo_level), 0);

    // configuration validation
    cfg(300, 20, 12, 3, 0, 0);
    chk(cur_rfs == 256, "R1 unsupported ratio falls back", int'(cur_rfs), 256);
    chk(cur_bfs == 32, "R2 unsupported bfs kept", int'(cur_bfs), 32);
    chk(cur_width == 16, "R3 unsupported width kept", int'(cur_width), 16);
    chk(cur_fmt == 0, "R4 format code 3 ignored", int'(cur_fmt), 0);
    cfg(768, 48, 24, 2, 0, 0);
    chk(cur_rfs == 768 && cur_bfs == 48 && cur_width == 24 && cur_fmt == 2,
        "R1 R2 R3 R4 legal values taken", int'(cur_rfs), 768);
    cfg(512, 7, 9, 3, 0, 0);
    chk(cur_rfs == 512 && cur_bfs == 48 && cur_width == 24 && cur_fmt == 2,
        "R2 R3 R4 illegal after legal keeps", int'(cur_bfs), 48);

    // FIFO full and flush
    cfg(256, 32, 16, 0, 0, 0);
    flush_fifo();
    for (int i = 0; i < DEPTH + 1; i++) push(24'(i + 1), 24'(i + 2));
    @(negedge clk);
    chk(fifo_level == DEPTH && fifo_full, "R9 full, extra write dropped", int'(fifo_level), DEPTH);
    fifo_flush = 1; wr_en = 1; tick(2); wr_en = 0;
    @(negedge clk);
    chk(fifo_level == 0 && !fifo_full, "R8 flush empties and drops writes", int'(fifo_level), 0);
    fifo_flush = 0; tick(1);

    // pause holds the FIFO and keeps data low
    for (int i = 0; i < 3; i++) push(24'h00ABCD, 24'h001234);
    tx_active = 1; tx_pause = 1; hi_seen = 0;
    for (int i = 0; i < 3 * 256; i++) begin
      @(negedge clk);
      if (sdata_o) hi_seen = 1;
    end
    chk(fifo_level == 3 && !hi_seen, "R7 paused path untouched", int'(fifo_level), 3);
    tick(1);
    tx_pause = 0;
    tick(2 * 256);
    @(negedge clk);
    lvl = int'(fifo_level);
    chk(lvl < 3, "R7 running path pops", lvl, 2);
    tx_active = 0; tick(1);
    flush_fifo();
    ur_clr = 1; tick(1); ur_clr = 0;

    // directed corner: right-justified with full-width half, inverted LR
    master_run(2, 1, 256, 32, 16, 3);
    // directed corner: I2S at the fastest bit clock
    master_run(0, 0, 256, 48, 16, 4);

    // constrained random master runs
    for (int it = 0; it < 6; it++) begin
      int f, rfs, bfs, w;
      f = int'($urandom % 3);
      rfs = rfs_tab[$urandom % 4];
      do begin
        bfs = bfs_tab[$urandom % 4];
        w = w_tab[$urandom % 3];
      end while (!((bfs / 2 >= w) && (f != 0 || bfs / 2 > w)));
      master_run(f, 1'($urandom % 2), rfs, bfs, w, 2 + int'($urandom % 4));
    end

    // slave mode, I2S, 12 slots per half, width 8
    cfg(256, 24, 8, 0, 0, 1);
    flush_fifo();
    sl = 24'h0000A5; sr = 24'h00003C;
    push(sl, sr);
    tx_active = 1;
    tick(2);
    @(negedge clk);
    chk(!bclk_o && !lrclk_o, "R6 slave outputs held low", int'(bclk_o), 0);
    tick(1);
    for (int j = 0; j < 12; j++) slave_bit(1'b1, b);
    gl = '0; gr = '0; hi_seen = 0;
    for (int j = 0; j < 12; j++) begin
      slave_bit(1'b0, b);
      if (j >= 1 && j <= 8) gl[8-j] = b; else if (b) hi_seen = 1;
    end
    for (int j = 0; j < 12; j++) begin
      slave_bit(1'b1, b);
      if (j >= 1 && j <= 8) gr[8-j] = b; else if (b) hi_seen = 1;
    end
    chk(gl == sl && gr == sr && !hi_seen, "R6 R4 slave frame decoded", int'(gl), int'(sl));
    gl = '0;
    for (int j = 0; j < 12; j++) begin
      slave_bit(1'b0, b);
      if (b) gl = 24'd1;
    end
    chk(gl == 0 && underrun, "R10 slave underrun sends zeros", int'(gl), 0);
    tx_active = 0;
    tick(4);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule